// File: doc/BRIEF.md
# Cascadable Hexadecimal Up/Down Counter

This block is a synchronous binary counter built from 4-bit stages. A two-bit select input picks one of four modes for every stage at once: parallel load, count up, count down or hold. The count changes only on the rising clock edge. The only other way it changes is an active-low asynchronous reset, which clears it.

Each stage takes an active-low carry-in and produces an active-low carry-out. The carry-out of a stage is driven combinationally from that stage's carry-in. This lets stages ripple their enables within one cycle, so a chain of N stages behaves as a single 4N-bit counter. The top module is such a chain. It has one external carry-in and one external carry-out, and its count and data buses are the concatenation of all the stages, with stage 0 in the low nibble.

A low carry-in lets the counter advance in either counting mode, and a high carry-in freezes it. The carry-out goes low when the chain sits at its terminal value in the current direction while carry-in is low. It is also low throughout load mode. A designer can therefore chain several of these blocks into a wider counter, or gate a counter from outside.

Top module: `hex_updown_chain`

## Requirements
- R1: While rst_ni is low, count_o is 0 at once, without waiting for a clock edge, and it stays 0 until rst_ni goes high.
- R2: With sel_i = 2'b00 (load), the rising edge of clk_i copies data_i into count_o. This happens whatever carry_n_i is.
- R3: With sel_i = 2'b01 (up) and carry_n_i low, each rising edge adds 1 to count_o. The count wraps from all ones to 0.
- R4: With sel_i = 2'b10 (down) and carry_n_i low, each rising edge subtracts 1 from count_o. The count wraps from 0 to all ones.
- R5: In up or down mode with carry_n_i high, count_o does not change, and carry_n_o is high.
- R6: With sel_i = 2'b11 (hold), count_o does not change whatever carry_n_i is, and carry_n_o is high.
- R7: With sel_i = 2'b00, carry_n_o is low.
- R8: In up mode, carry_n_o is low exactly when carry_n_i is low and count_o is all ones. The next edge then wraps the count to 0.
- R9: In down mode, carry_n_o is low exactly when carry_n_i is low and count_o is 0. The next edge then wraps the count to all ones.
- R10: carry_n_o follows carry_n_i combinationally, within the same cycle and with no clock edge. This holds in every stage of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the count changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the count |
| data_i | input | 4*N_STAGES | Parallel load value, stage 0 in bits 3:0 |
| sel_i | input | 2 | Mode: 00 load, 01 up, 10 down, 11 hold |
| carry_n_i | input | 1 | Active-low count enable for stage 0 |
| count_o | output | 4*N_STAGES | Current count, stage 0 in bits 3:0 |
| carry_n_o | output | 1 | Active-low carry-out of the last stage |

## Verification
The count register is the only state, so every load, increment, decrement or freeze takes effect at the first rising edge after the inputs are set. The bench drives inputs on a falling edge and checks count_o on the next falling edge. carry_n_o has no register on its path, so it is checked 1 ns after the inputs change, before any edge follows. The asynchronous reset is checked in the middle of a cycle, before the next edge.

// File: rtl/hex_cnt_pkg.sv
package hex_cnt_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_HOLD = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/hex_cnt_ctrl.sv
module hex_cnt_ctrl
  import hex_cnt_pkg::*;
(
  input  logic [1:0] sel_i,
  output cnt_mode_e  mode_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   mode_o = MODE_LOAD;
      2'b01:   mode_o = MODE_UP;
      2'b10:   mode_o = MODE_DOWN;
      default: mode_o = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/hex_cnt_carry.sv
module hex_cnt_carry
  import hex_cnt_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  cnt_mode_e      mode_i,
  input  logic [W-1:0]   count_i,
  input  logic           carry_n_i,
  output logic           adv_o,
  output logic           carry_n_o
);
  logic at_top, at_bot;

  assign at_top = &count_i;
  assign at_bot = ~|count_i;

  always_comb begin
    adv_o     = 1'b0;
    carry_n_o = 1'b1;
    unique case (mode_i)
      MODE_LOAD: carry_n_o = 1'b0;
      MODE_UP: begin
        adv_o     = ~carry_n_i;
        carry_n_o = ~(~carry_n_i & at_top);
      end
      MODE_DOWN: begin
        adv_o     = ~carry_n_i;
        carry_n_o = ~(~carry_n_i & at_bot);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hex_cnt_next.sv
module hex_cnt_next
  import hex_cnt_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] data_i,
  input  logic         adv_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    count_o = count_i;
    unique case (mode_i)
      MODE_LOAD: count_o = data_i;
      MODE_UP:   if (adv_i) count_o = count_i + ONE;
      MODE_DOWN: if (adv_i) count_o = count_i - ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/hex_cnt_stage.sv
module hex_cnt_stage
  import hex_cnt_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] data_i,
  input  logic         carry_n_i,
  output logic [W-1:0] count_o,
  output logic         carry_n_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] q_q, q_d;
  logic         adv;

  hex_cnt_carry #(.W(W)) u_carry (
    .mode_i    (mode_i),
    .count_i   (q_q),
    .carry_n_i (carry_n_i),
    .adv_o     (adv),
    .carry_n_o (carry_n_o)
  );

  hex_cnt_next #(.W(W)) u_next (
    .mode_i  (mode_i),
    .count_i (q_q),
    .data_i  (data_i),
    .adv_i   (adv),
    .count_o (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign count_o = q_q;

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_LOAD |=> q_q == $past(data_i));
  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && !carry_n_i) |=> q_q == $past(q_q) + ONE);
  // R4
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN && !carry_n_i) |=> q_q == $past(q_q) - ONE);
  // R5
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_UP || mode_i == MODE_DOWN) && carry_n_i) |=> $stable(q_q));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_HOLD |=> $stable(q_q));
  // R7
  load_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_LOAD |-> !carry_n_o);
  // R8
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && !carry_n_o) |=> q_q == '0);
  // R9
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN && !carry_n_o) |=> q_q == '1);
endmodule

// File: rtl/hex_updown_chain.sv
module hex_updown_chain
  import hex_cnt_pkg::*;
#(
  parameter int unsigned N_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NIB_W*N_STAGES-1:0] data_i,
  input  logic [1:0]                sel_i,
  input  logic                      carry_n_i,
  output logic [NIB_W*N_STAGES-1:0] count_o,
  output logic                      carry_n_o
);
  localparam int unsigned TOT_W = NIB_W * N_STAGES;

  cnt_mode_e           mode;
  logic [N_STAGES:0]   carry_n;

  hex_cnt_ctrl u_ctrl (
    .sel_i  (sel_i),
    .mode_o (mode)
  );

  assign carry_n[0] = carry_n_i;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    hex_cnt_stage #(.W(NIB_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode),
      .data_i    (data_i[g*NIB_W +: NIB_W]),
      .carry_n_i (carry_n[g]),
      .count_o   (count_o[g*NIB_W +: NIB_W]),
      .carry_n_o (carry_n[g+1])
    );
  end

  assign carry_n_o = carry_n[N_STAGES];

  // R10: disabled carry-in blocks the whole chain in counting modes
  chain_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_n_i && (mode == MODE_UP || mode == MODE_DOWN)) |-> carry_n_o);
  // R3
  chain_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_UP && !carry_n_i) |=> count_o == $past(count_o) + TOT_W'(1));
endmodule

// File: tb/hex_updown_chain_test.sv
module hex_updown_chain_test;
  localparam int N = 2;
  localparam int W = 4 * N;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [1:0]   sel_i = 2'b11;
  logic         carry_n_i = 1'b1;
  logic [W-1:0] count_o;
  logic         carry_n_o;

  int           total = 0;
  int           bad = 0;
  logic [W-1:0] ref_cnt = '0;

  always #5 clk = ~clk;

  hex_updown_chain #(.N_STAGES(N)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .sel_i     (sel_i),
    .carry_n_i (carry_n_i),
    .count_o   (count_o),
    .carry_n_o (carry_n_o)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_cout(logic [1:0] s, logic cin, logic [W-1:0] c);
    case (s)
      2'b00:   return 1'b0;
      2'b01:   return ~(~cin & (c == '1));
      2'b10:   return ~(~cin & (c == '0));
      default: return 1'b1;
    endcase
  endfunction

  // called on a falling edge; returns on the next falling edge
  task automatic step(string req, logic [1:0] s, logic cin, logic [W-1:0] d);
    sel_i = s; carry_n_i = cin; data_i = d;
    #1;
    chk({req, " carry"}, {{(W-1){1'b0}}, carry_n_o}, {{(W-1){1'b0}}, exp_cout(s, cin, ref_cnt)});
    @(posedge clk);
    case (s)
      2'b00: ref_cnt = d;
      2'b01: if (!cin) ref_cnt = ref_cnt + 1'b1;
      2'b10: if (!cin) ref_cnt = ref_cnt - 1'b1;
      default: ;
    endcase
    @(negedge clk);
    chk({req, " count"}, count_o, ref_cnt);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", count_o, '0);
    rst_ni = 1'b1;
    ref_cnt = '0;
  endtask

  task automatic t_async_reset();
    step("R2 preload", 2'b00, 1'b1, 8'h5A);
    #2 rst_ni = 1'b0;
    #1 chk("R1 async clear", count_o, '0);
    @(negedge clk);
    chk("R1 held in reset", count_o, '0);
    rst_ni = 1'b1;
    ref_cnt = '0;
  endtask

  task automatic t_load();
    step("R2 load cin high", 2'b00, 1'b1, 8'hC3);
    step("R2 load cin low", 2'b00, 1'b0, 8'h3C);
    step("R7 load carry", 2'b00, 1'b0, 8'hFF);
  endtask

  task automatic t_up();
    step("R2 load F8", 2'b00, 1'b0, 8'hF8);
    for (int i = 0; i < 12; i++) step("R3 R8 up", 2'b01, 1'b0, 8'h00);
    step("R3 load 0E", 2'b00, 1'b0, 8'h0E);
    for (int i = 0; i < 4; i++) step("R3 nibble carry", 2'b01, 1'b0, 8'h00);
  endtask

  task automatic t_down();
    step("R2 load 05", 2'b00, 1'b0, 8'h05);
    for (int i = 0; i < 10; i++) step("R4 R9 down", 2'b10, 1'b0, 8'h00);
    step("R4 load 11", 2'b00, 1'b0, 8'h11);
    for (int i = 0; i < 3; i++) step("R4 nibble borrow", 2'b10, 1'b0, 8'h00);
  endtask

  task automatic t_gate();
    step("R2 load FF", 2'b00, 1'b0, 8'hFF);
    for (int i = 0; i < 3; i++) step("R5 up gated", 2'b01, 1'b1, 8'h00);
    step("R2 load 00", 2'b00, 1'b0, 8'h00);
    for (int i = 0; i < 3; i++) step("R5 down gated", 2'b10, 1'b1, 8'h00);
  endtask

  task automatic t_hold();
    step("R2 load 7E", 2'b00, 1'b0, 8'h7E);
    step("R6 hold cin low", 2'b11, 1'b0, 8'h11);
    step("R6 hold cin high", 2'b11, 1'b1, 8'h22);
  endtask

  task automatic t_comb();
    step("R2 load FF", 2'b00, 1'b0, 8'hFF);
    sel_i = 2'b01; carry_n_i = 1'b0;
    #1 chk("R10 carry low", {{(W-1){1'b0}}, carry_n_o}, '0);
    carry_n_i = 1'b1;
    #1 chk("R10 carry high", {{(W-1){1'b0}}, carry_n_o}, {{(W-1){1'b0}}, 1'b1});
    carry_n_i = 1'b0;
    #1 chk("R10 carry low again", {{(W-1){1'b0}}, carry_n_o}, '0);
    sel_i = 2'b11;
    @(negedge clk);
    chk("R6 count kept", count_o, ref_cnt);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_up();
    t_down();
    t_gate();
    t_hold();
    t_comb();
    t_async_reset();
    t_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule